// File: doc/BRIEF.md
# Multiplexed LCD Common and Segment Scanner

This block drives a multiplexed liquid-crystal panel from a small display memory of 32 words of 4 bits. On every LCD clock tick it moves to the next common line. For the common that is currently selected, it puts out a 2-bit drive-level code on each of the 4 common pins and each of the 32 segment pins. A level shifter or analog switch outside the block turns each code into a voltage. Generating those voltages is outside this block.

Two settings control the scan. The duty setting picks 2, 3 or 4 active commons. The bias setting picks a one-third or one-half level scheme. The polarity of every drive flips after each complete scan, so each pixel sees zero average DC. Word k of the memory belongs to segment k, and bit n of that word belongs to common n. The host fills the memory through a simple synchronous write port. When the display is disabled, every output is held at ground.

Top module: `lcd_scan_top`

## Requirements
- R1: While `rst` is high and on the first clock after it, every common and segment code is 0 (ground). The scan restarts at common 0 with normal polarity.
- R2: Level codes are 0 = ground, 1 = lower middle, 2 = upper middle and 3 = full LCD voltage. With `bias_third` low, every middle drive uses code 1, which stands for half voltage.
- R3: `duty_sel` 2'b01 selects 2 active commons, 2'b10 selects 3, and 2'b11 or 2'b00 selects 4. A common at or above the active count is driven with code 0.
- R4: Each `tick` cycle advances the scan by one common. After the last active common, the scan returns to common 0, so one full scan takes n ticks. The outputs show the new common one clock after the tick edge.
- R5: Drive polarity inverts every time the scan wraps back to common 0.
- R6: Under normal polarity, the selected common is code 3 and unselected active commons use the lower middle code. Under inverted polarity, the selected common is code 0 and unselected active commons use the upper middle code.
- R7: A segment whose bit is set gets the extreme opposite to the selected common: 0 under normal polarity and 3 under inverted. A clear bit gets the upper middle code under normal polarity and the lower middle code under inverted.
- R8: Segment k shows bit n of word k while common n is selected. Codes are packed 2 bits per pin, with pin k at bits [2k+1:2k].
- R9: While `lcd_en` is low, all outputs are code 0 from the next clock on, and the scan is held at common 0 with normal polarity. Ticks have no effect while `lcd_en` is low.
- R10: If `duty_sel` is reduced so that the current common is at or beyond the new last active common, the next tick wraps the scan to common 0 and inverts polarity.
- R11: A write on the memory port reaches the segment outputs on the clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_en | input | 1 | Display enable |
| duty_sel | input | 2 | Active common count select |
| bias_third | input | 1 | 1: one-third bias, 0: one-half bias |
| tick | input | 1 | One-cycle LCD clock tick |
| wr_en | input | 1 | Display memory write strobe |
| wr_addr | input | 5 | Display memory word address |
| wr_data | input | 4 | Display memory word, bit n for common n |
| com_lvl | output | 8 | Common level codes, 2 bits per common |
| seg_lvl | output | 64 | Segment level codes, 2 bits per segment |

## Verification
A wrong common index appears on the very next output update, because the extreme code moves to the wrong common pin and the segment pattern changes to another memory column. A polarity register that is stuck or toggles at the wrong time shows up within one full scan, since every code is then mirrored about the middle at the wrong moment. A wrap point that is off by one shows up after n ticks, as a common that should be inactive being driven, or as a scan that never reaches its last common. Write-path faults show up one clock after the write as a wrong segment code.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_FULL = 2'd3
  } lvl_t;

  localparam logic [1:0] DUTY_TWO   = 2'b01;
  localparam logic [1:0] DUTY_THREE = 2'b10;
endpackage

// File: rtl/lcd_disp_mem.sv
module lcd_disp_mem #(
  parameter int NUM_SEG = 32,
  parameter int NUM_COM = 4,
  localparam int ADDR_W = $clog2(NUM_SEG),
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_COM-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_com,
  output logic [NUM_SEG-1:0] seg_bits
);
  logic [NUM_COM-1:0] words [NUM_SEG];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_addr] <= wr_data;
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_col
    assign seg_bits[k] = words[k][rd_com];
  end
endmodule

// File: rtl/lcd_com_seq.sv
module lcd_com_seq #(
  parameter int NUM_COM = 4,
  localparam int IDX_W = $clog2(NUM_COM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [1:0]       duty_sel,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] last,
  output logic             inv
);
  import lcd_scan_pkg::*;

  always_comb begin
    case (duty_sel)
      DUTY_TWO:   last = IDX_W'(1);
      DUTY_THREE: last = IDX_W'(2);
      default:    last = IDX_W'(NUM_COM - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      idx <= '0;
      inv <= 1'b0;
    end else if (tick) begin
      if (idx >= last) begin
        idx <= '0;
        inv <= ~inv;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  assert_wrap_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (en && tick && idx >= last) |=> (idx == '0 && inv != $past(inv)));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (en && tick && idx < last) |=> (idx == $past(idx) + IDX_W'(1) && $stable(inv)));

  assert_hold_off_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (idx == '0 && !inv));
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc #(
  parameter int NUM_SEG = 32,
  parameter int NUM_COM = 4,
  localparam int IDX_W = $clog2(NUM_COM)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   bias_third,
  input  logic [IDX_W-1:0]       idx,
  input  logic [IDX_W-1:0]       last,
  input  logic                   inv,
  input  logic [NUM_SEG-1:0]     seg_bits,
  output logic [2*NUM_COM-1:0]   com_lvl,
  output logic [2*NUM_SEG-1:0]   seg_lvl
);
  import lcd_scan_pkg::*;

  lvl_t mid_lo, mid_hi;
  assign mid_lo = LVL_LOW;
  assign mid_hi = bias_third ? LVL_HIGH : LVL_LOW;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    lvl_t nxt;
    always_comb begin
      if (!en || IDX_W'(c) > last) nxt = LVL_GND;
      else if (IDX_W'(c) == idx)   nxt = inv ? LVL_GND : LVL_FULL;
      else                         nxt = inv ? mid_hi : mid_lo;
    end
    always_ff @(posedge clk) begin
      if (rst) com_lvl[2*c +: 2] <= LVL_GND;
      else     com_lvl[2*c +: 2] <= nxt;
    end
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    lvl_t nxt;
    always_comb begin
      if (!en)              nxt = LVL_GND;
      else if (seg_bits[k]) nxt = inv ? LVL_FULL : LVL_GND;
      else                  nxt = inv ? mid_lo : mid_hi;
    end
    always_ff @(posedge clk) begin
      if (rst) seg_lvl[2*k +: 2] <= LVL_GND;
      else     seg_lvl[2*k +: 2] <= nxt;
    end
  end

  assert_dark_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (com_lvl == '0 && seg_lvl == '0));

  assert_selected_extreme_R6: assert property (@(posedge clk) disable iff (rst)
    (en && idx <= last && !inv) |=> (com_lvl[2*$past(idx) +: 2] == 2'd3));
endmodule

// File: rtl/lcd_scan_top.sv
module lcd_scan_top #(
  parameter int NUM_SEG = 32,
  parameter int NUM_COM = 4,
  localparam int ADDR_W = $clog2(NUM_SEG),
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lcd_en,
  input  logic [1:0]           duty_sel,
  input  logic                 bias_third,
  input  logic                 tick,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NUM_COM-1:0]   wr_data,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl
);
  logic [IDX_W-1:0]   idx, last;
  logic               inv;
  logic [NUM_SEG-1:0] seg_bits;

  lcd_com_seq #(.NUM_COM(NUM_COM)) seq_i (
    .clk(clk), .rst(rst), .en(lcd_en), .tick(tick), .duty_sel(duty_sel),
    .idx(idx), .last(last), .inv(inv)
  );

  lcd_disp_mem #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) mem_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_com(idx), .seg_bits(seg_bits)
  );

  lcd_level_enc #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) enc_i (
    .clk(clk), .rst(rst), .en(lcd_en), .bias_third(bias_third),
    .idx(idx), .last(last), .inv(inv), .seg_bits(seg_bits),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );
endmodule

// File: tb/lcd_scan_top_tb_top.sv
`timescale 1ns/1ps
module lcd_scan_top_tb_top;
  localparam int NS = 32;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lcd_en = 1'b0;
  logic [1:0] duty_sel = 2'b11;
  logic bias_third = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  logic [3:0] shadow [NS];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lcd_scan_top dut_i (
    .clk(clk), .rst(rst), .lcd_en(lcd_en), .duty_sel(duty_sel),
    .bias_third(bias_third), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // {duty_sel, bias_third, tick count}
  localparam logic [9:0] VEC [6] = '{
    {2'b11, 1'b1, 7'd9}, {2'b01, 1'b1, 7'd5}, {2'b10, 1'b0, 7'd7},
    {2'b00, 1'b0, 7'd9}, {2'b10, 1'b1, 7'd7}, {2'b11, 1'b0, 7'd9}
  };

  function automatic int active_n(input logic [1:0] d);
    return (d == 2'b01) ? 2 : (d == 2'b10) ? 3 : 4;
  endfunction

  function automatic logic [2*NC-1:0] exp_com(input logic en, input logic [1:0] d,
      input logic b3, input int ix, input logic iv);
    logic [2*NC-1:0] r;
    logic [1:0] mh;
    r = '0;
    mh = b3 ? 2'd2 : 2'd1;
    for (int c = 0; c < NC; c++) begin
      if (!en || c >= active_n(d)) r[2*c +: 2] = 2'd0;
      else if (c == ix)            r[2*c +: 2] = iv ? 2'd0 : 2'd3;
      else                         r[2*c +: 2] = iv ? mh : 2'd1;
    end
    return r;
  endfunction

  function automatic logic [2*NS-1:0] exp_seg(input logic en, input logic b3,
      input int ix, input logic iv);
    logic [2*NS-1:0] r;
    logic [1:0] mh;
    r = '0;
    mh = b3 ? 2'd2 : 2'd1;
    for (int k = 0; k < NS; k++) begin
      if (!en)                r[2*k +: 2] = 2'd0;
      else if (shadow[k][ix]) r[2*k +: 2] = iv ? 2'd3 : 2'd0;
      else                    r[2*k +: 2] = iv ? 2'd1 : mh;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [2*NS-1:0] act,
                       input logic [2*NS-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_state(input string req, input int ix, input logic iv);
    check(req, {{(2*NS-2*NC){1'b0}}, com_lvl},
          {{(2*NS-2*NC){1'b0}}, exp_com(lcd_en, duty_sel, bias_third, ix, iv)});
    check(req, seg_lvl, exp_seg(lcd_en, bias_third, ix, iv));
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_word(input int a, input logic [3:0] d);
    wr_en = 1'b1;
    wr_addr = 5'(a);
    wr_data = d;
    shadow[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic restart(input logic [1:0] d, input logic b3);
    lcd_en = 1'b0;
    duty_sel = d;
    bias_third = b3;
    repeat (2) @(negedge clk);
    lcd_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 com", {{(2*NS-2*NC){1'b0}}, com_lvl}, '0);
    check("R1 seg", seg_lvl, '0);
    rst = 1'b0;
    for (int k = 0; k < NS; k++) write_word(k, 4'((k * 7 + 3) & 15));
    @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      restart(VEC[v][9:8], VEC[v][7]);
      check_state("R1/R6/R7 start", 0, 1'b0);
      for (int t = 1; t <= int'(VEC[v][6:0]); t++) begin
        pulse_tick();
        check_state("R2/R3/R4/R5/R8 scan", t % active_n(VEC[v][9:8]),
                    1'((t / active_n(VEC[v][9:8])) % 2));
      end
    end

    // R9: disable grounds everything, ticks ignored
    restart(2'b11, 1'b1);
    pulse_tick();
    lcd_en = 1'b0;
    @(negedge clk);
    check("R9 com off", {{(2*NS-2*NC){1'b0}}, com_lvl}, '0);
    check("R9 seg off", seg_lvl, '0);
    pulse_tick();
    pulse_tick();
    check("R9 tick ignored", seg_lvl, '0);
    lcd_en = 1'b1;
    @(negedge clk);
    check_state("R9 resumes at com0", 0, 1'b0);

    // R10: shrink duty while at common 3
    restart(2'b11, 1'b1);
    for (int t = 0; t < 3; t++) pulse_tick();
    check_state("R10 at com3", 3, 1'b0);
    duty_sel = 2'b01;
    @(negedge clk);
    check_state("R10 com3 inactive", 3, 1'b0);
    pulse_tick();
    check_state("R10 wrap", 0, 1'b1);

    // R11: write while scanning, visible one edge later
    restart(2'b11, 1'b1);
    wr_en = 1'b1; wr_addr = 5'd31; wr_data = ~shadow[31]; shadow[31] = ~shadow[31];
    @(posedge clk);
    #1 wr_en = 1'b0;
    @(posedge clk);
    #1;
    check("R11 write seen", seg_lvl, exp_seg(1'b1, 1'b1, 0, 1'b0));
    write_word(0, 4'hF);
    write_word(5, 4'h0);
    @(negedge clk);
    check_state("R8 all on / all off words", 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule